// File: doc/BRIEF.md
# Base-Change Constant Multiplier

This block turns a signed binary logarithm into a logarithm of another base. It multiplies the value by a fixed fraction 1/log2(base). The fraction is set at elaboration as a bit pattern `K_BITS` of `K_W` fractional bits. The multiply is a sequential shift-and-add loop. Zero bits of the constant at either end are never visited. The lowest set bit, together with the zeros just above it, is folded into the accumulator load, so the loop only walks the bits from the next set bit up to the top set bit.

The default constant is 0.01001101000100 (4932/16384, base 10). It needs one load cycle plus 7 loop steps. With `BYPASS` = 1 the constant is taken as exactly 1.0 for base 2. The loop is removed, and only the change of fixed-point format remains.

Both data sides use valid/ready. A word moves on a clock edge where valid and ready are both high. The producer must hold `in_valid` and `in_a` until that edge. The block holds `out_valid` and `out_data` until `out_ready` takes them. While the block is working or holding a result, it gives no `in_ready`. The one exception is the cycle in which the held result drains: a new operand may enter on that same edge.

Top module: `base_change_mul`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: `out_data` equals floor(A * K_BITS / 2^(K_W + IN_FRAC - OUT_FRAC)), kept to its low OUT_W bits, where A is `in_a` read as two's complement. With the defaults this is floor(A * 4932 / 16384).
- R3: A negative A gives a two's-complement result that is rounded toward minus infinity.
- R4: The loop covers the constant bits from the second-lowest set bit up to the highest set bit. `out_valid` rises exactly that many clock edges after the accepting edge. For the default constant this is 7 edges: bits 0 to 5 are folded into the load and bits 6 to 12 are stepped.
- R5: `in_ready` is 0 while the loop runs. It is also 0 while a result is held with `out_ready` low.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` stay unchanged on the next cycle.
- R7: If a result drains while `in_valid` is high, the new operand is accepted on the same edge. Back-to-back operands are then accepted every 8 edges with the default constant.
- R8: With `BYPASS` = 1, `out_valid` is high in the cycle right after the accepting edge. `out_data` is A rescaled from IN_FRAC to OUT_FRAC fraction bits, truncated toward minus infinity.
- R9: The extreme inputs 0x7FFF and 0x8000 give 9863 and -9864 with the defaults.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand can be taken this cycle |
| in_a | input | IN_W | Signed base-2 logarithm, IN_FRAC fraction bits |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | OUT_W | Signed logarithm in the chosen base, OUT_FRAC fraction bits |

## Verification
Draining a finished result and accepting the next operand can happen on the same edge. The bench provokes this by keeping `in_valid` high through a run of operands while `out_ready` stays high. It then checks two things: the accepting edges are exactly 8 apart, and the scoreboard sees every result in order with no value lost or repeated. Other runs use a toggling `out_ready` and a long stall. These check that held results stay fixed and that no operand slips in while a result waits.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } bcm_state_e;

  // index of the lowest set bit among the low w bits (0 when none)
  function automatic int lowest_one(input logic [63:0] k, input int w);
    for (int i = 0; i < w; i++) begin
      if (k[i]) return i;
    end
    return 0;
  endfunction

  // index of the highest set bit among the low w bits (0 when none)
  function automatic int highest_one(input logic [63:0] k, input int w);
    for (int i = w - 1; i >= 0; i--) begin
      if (k[i]) return i;
    end
    return 0;
  endfunction

  // first set bit strictly above position 'from', -1 when none
  function automatic int next_one(input logic [63:0] k, input int w, input int from);
    for (int i = from + 1; i < w; i++) begin
      if (k[i]) return i;
    end
    return -1;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bcm_ctrl.sv
module bcm_ctrl
  import bcm_pkg::*;
#(
  parameter int STEPS = 7,
  parameter int FIRST = 6,
  parameter int LAST  = 12,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             load,
  output logic             step,
  output logic [IDX_W-1:0] idx
);

  localparam int CNT_W = $clog2(STEPS + 2);

  bcm_state_e state_q, state_d;
  logic [CNT_W-1:0] run_cnt_q;

  assign in_ready  = (state_q == ST_IDLE) || ((state_q == ST_DONE) && out_ready);
  assign out_valid = (state_q == ST_DONE);
  assign load      = in_valid && in_ready;
  assign step      = (state_q == ST_RUN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (load) state_d = (STEPS == 0) ? ST_DONE : ST_RUN;
      ST_RUN:  if (idx == IDX_W'(LAST)) state_d = ST_DONE;
      ST_DONE: begin
        if (load)           state_d = (STEPS == 0) ? ST_DONE : ST_RUN;
        else if (out_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      idx       <= '0;
      run_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (load) begin
        idx       <= IDX_W'(FIRST);
        run_cnt_q <= '0;
      end else if (step) begin
        idx       <= idx + 1'b1;
        run_cnt_q <= run_cnt_q + 1'b1;
      end
    end
  end

  // R4
  step_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (int'(run_cnt_q) < STEPS));

  // R4
  step_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (idx >= IDX_W'(FIRST)) && (idx <= IDX_W'(LAST)));

  // R5
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step || (out_valid && !out_ready)) |-> !in_ready);

endmodule

// File: rtl/bcm_datapath.sv
module bcm_datapath #(
  parameter int             IN_W     = 16,
  parameter int             ACC_W    = 31,
  parameter int             K_W      = 14,
  parameter logic [K_W-1:0] K_BITS   = 14'b01001101000100,
  parameter int             LOAD_SH  = 2,
  parameter int             FIRST    = 6,
  parameter int             IDX_W    = 5,
  parameter bit             HAS_LOOP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [IN_W-1:0]  a_in,
  input  logic [IDX_W-1:0] idx,
  output logic [ACC_W-1:0] acc
);

  logic [ACC_W-1:0] a_ext;
  logic [ACC_W-1:0] addend;
  logic             kbit;

  assign a_ext = {{(ACC_W-IN_W){a_in[IN_W-1]}}, a_in};

  generate
    if (HAS_LOOP) begin : g_loop
      logic [ACC_W-1:0] addend_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    addend_q <= '0;
        else if (load) addend_q <= a_ext << FIRST;
        else if (step) addend_q <= addend_q << 1;
      end

      always_comb begin
        kbit = 1'b0;
        for (int i = 0; i < K_W; i++) begin
          if (idx == IDX_W'(i)) kbit = K_BITS[i];
        end
      end

      assign addend = addend_q;
    end else begin : g_noloop
      assign addend = '0;
      assign kbit   = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            acc <= '0;
    else if (load)         acc <= a_ext << LOAD_SH;
    else if (step && kbit) acc <= acc + addend;
  end

  // R2
  zero_bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !kbit && !load) |=> $stable(acc));

endmodule

// File: rtl/bcm_outfmt.sv
module bcm_outfmt #(
  parameter int ACC_W = 31,
  parameter int SHR   = 14,
  parameter int OUT_W = 16
) (
  input  logic [ACC_W-1:0] acc,
  output logic [OUT_W-1:0] out_data
);

  logic signed [ACC_W-1:0] shifted;

  assign shifted  = $signed(acc) >>> SHR;
  assign out_data = shifted[OUT_W-1:0];

endmodule

// File: rtl/base_change_mul.sv
module base_change_mul
  import bcm_pkg::*;
#(
  parameter int             IN_W     = 16,
  parameter int             IN_FRAC  = 10,
  parameter int             OUT_W    = 16,
  parameter int             OUT_FRAC = 10,
  parameter int             K_W      = 14,
  parameter logic [K_W-1:0] K_BITS   = 14'b01001101000100,
  parameter bit             BYPASS   = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_a,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);

  localparam int LOW     = lowest_one(64'(K_BITS), K_W);
  localparam int HIGH    = highest_one(64'(K_BITS), K_W);
  localparam int NXT     = next_one(64'(K_BITS), K_W, LOW);
  localparam bit LOOP    = !BYPASS && (NXT >= 0);
  localparam int STEPS   = LOOP ? (HIGH - NXT + 1) : 0;
  localparam int FIRST   = LOOP ? NXT : 0;
  localparam int LAST    = LOOP ? HIGH : 0;
  localparam int LOAD_SH = BYPASS ? K_W : LOW;
  localparam int SHR     = K_W + IN_FRAC - OUT_FRAC;
  localparam int ACC_W   = imax(IN_W + K_W + 1, SHR + OUT_W);
  localparam int IDX_W   = $clog2(K_W + 1) + 1;

  logic             load, step;
  logic [IDX_W-1:0] idx;
  logic [ACC_W-1:0] acc;

  bcm_ctrl #(
    .STEPS (STEPS),
    .FIRST (FIRST),
    .LAST  (LAST),
    .IDX_W (IDX_W)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .load      (load),
    .step      (step),
    .idx       (idx)
  );

  bcm_datapath #(
    .IN_W     (IN_W),
    .ACC_W    (ACC_W),
    .K_W      (K_W),
    .K_BITS   (K_BITS),
    .LOAD_SH  (LOAD_SH),
    .FIRST    (FIRST),
    .IDX_W    (IDX_W),
    .HAS_LOOP (LOOP)
  ) dp_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .a_in  (in_a),
    .idx   (idx),
    .acc   (acc)
  );

  bcm_outfmt #(
    .ACC_W (ACC_W),
    .SHR   (SHR),
    .OUT_W (OUT_W)
  ) fmt_i (
    .acc      (acc),
    .out_data (out_data)
  );

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7
  drain_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && in_valid) |=> (out_valid == (STEPS == 0)));

  // R8
  bypass_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (BYPASS && in_valid && in_ready) |=> out_valid);

endmodule

// File: tb/base_change_mul_tb_top.sv
`timescale 1ns/1ps
module base_change_mul_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int edge_cnt = 0;
  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  // main instance, base 10 constant
  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic [15:0] in_a = '0;
  logic        in_ready, out_valid;
  logic [15:0] out_data;

  base_change_mul #(
    .IN_W(16), .IN_FRAC(10), .OUT_W(16), .OUT_FRAC(10),
    .K_W(14), .K_BITS(14'b01001101000100), .BYPASS(1'b0)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // base-2 instance, format change 10 -> 8 fraction bits
  logic        b_in_valid = 1'b0;
  logic [15:0] b_in_a = '0;
  logic        b_in_ready, b_out_valid;
  logic [15:0] b_out_data;

  base_change_mul #(
    .IN_W(16), .IN_FRAC(10), .OUT_W(16), .OUT_FRAC(8),
    .K_W(14), .K_BITS(14'b01001101000100), .BYPASS(1'b1)
  ) dut_b_i (
    .clk(clk), .rst_n(rst_n), .in_valid(b_in_valid), .in_ready(b_in_ready),
    .in_a(b_in_a), .out_valid(b_out_valid), .out_ready(1'b1), .out_data(b_out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [15:0] a);
    longint p;
    p = longint'($signed(a)) * 64'sd4932;
    return 16'(p >>> 14);
  endfunction

  logic [15:0] sb[$];
  int ready_mode = 0;

  // consumer ready pattern
  always @(posedge clk) begin
    #1;
    case (ready_mode)
      0: out_ready = 1'b1;
      1: out_ready = edge_cnt[0] ^ edge_cnt[2];
      default: out_ready = 1'b0;
    endcase
  end

  // monitor: pops the scoreboard and watches held results
  initial begin
    logic        held_v;
    logic [15:0] held_d;
    logic [15:0] e;
    held_v = 1'b0;
    held_d = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (held_v)  // R6 held result unchanged
          check(out_valid && out_data == held_d, "R6", int'($signed(out_data)), int'($signed(held_d)));
        held_v = 1'b0;
        if (out_valid && out_ready) begin
          if (sb.size() == 0) begin
            check(1'b0, "R2 unexpected output", int'($signed(out_data)), 0);
          end else begin
            e = sb.pop_front();
            // R2 R3 R9 exact truncated product
            check(out_data == e, "R2/R3", int'($signed(out_data)), int'($signed(e)));
          end
        end else if (out_valid) begin
          held_v = 1'b1;
          held_d = out_data;
        end
      end
    end
  end

  task automatic send(input logic [15:0] a, output int acc_edge);
    bit go;
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_a = a;
    forever begin
      @(negedge clk);
      go = in_ready;
      @(posedge clk);
      if (go) break;
    end
    #1;
    acc_edge = edge_cnt;
    sb.push_back(model(a));
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_b(input logic [15:0] a);
    logic [15:0] e;
    e = 16'($signed(a) >>> 2);
    @(posedge clk); #1;
    b_in_valid = 1'b1;
    b_in_a = a;
    @(negedge clk);
    check(b_in_ready, "R8 ready", int'(b_in_ready), 1);
    @(posedge clk); #1;
    b_in_valid = 1'b0;
    @(negedge clk);
    // R8 result one cycle after acceptance
    check(b_out_valid && b_out_data == e, "R8", int'($signed(b_out_data)), int'($signed(e)));
  endtask

  initial begin
    #(100000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t0, lat;
    int edges[4];
    logic [15:0] vals[12];
    vals = '{16'h0400, 16'h0001, 16'hFFFF, 16'hFC00, 16'h1234, 16'hABCD,
             16'h7FFF, 16'h8000, 16'h0000, 16'h2A5F, 16'hC3B1, 16'h0D2E};

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(!out_valid && in_ready, "R1", int'({out_valid, in_ready}), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1", int'({out_valid, in_ready}), 1);

    // R4 latency and R5 no acceptance while busy
    ready_mode = 0;
    send(16'h0C00, t0);
    lat = 0;
    forever begin
      @(negedge clk);
      if (out_valid) break;
      check(!in_ready, "R5 busy", int'(in_ready), 0);
    end
    lat = edge_cnt - t0;
    check(lat == 7, "R4 latency", lat, 7);
    drain();

    // R9 extremes, R3 negatives, R2 mixed under toggling ready
    ready_mode = 1;
    foreach (vals[i]) send(vals[i], t0);
    drain();

    // R5 and R6 under a long stall
    ready_mode = 2;
    send(16'hF123, t0);
    repeat (14) begin
      @(negedge clk);
      if (out_valid) check(!in_ready, "R5 stall", int'(in_ready), 0);
    end
    check(out_valid, "R6 stall", int'(out_valid), 1);
    ready_mode = 0;
    drain();

    // R7 drain and refill on the same edge
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b1;
      in_a = 16'(16'h0321 * (i + 1)) ^ 16'h8000;
      forever begin
        @(negedge clk);
        if (in_ready) begin
          @(posedge clk); #1;
          break;
        end
        @(posedge clk);
      end
      edges[i] = edge_cnt;
      sb.push_back(model(in_a));
    end
    in_valid = 1'b0;
    for (int i = 1; i < 4; i++)
      check(edges[i] - edges[i-1] == 8, "R7 spacing", edges[i] - edges[i-1], 8);
    drain();

    // R8 bypass variant
    send_b(16'h0400);
    send_b(16'hFFFF);
    send_b(16'h8003);
    send_b(16'h7FFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule